// File: doc/BRIEF.md
# Multiplexed Program-Bus Fetch Sequencer

This block sequences code reads for a small 8-bit controller whose program memory sits partly on chip and partly behind a shared address/data bus. It drives several pins:

- a combined port that carries the low address byte and then the read data;
- a high-address port;
- an address-latch strobe, active high;
- an active-low read strobe.

It keeps its own fetch pointer. A built-in opcode classifier gives each instruction's byte count and cycle count, and an external table address feeds the lookup read.

Every machine cycle is two fetch slots long, and each slot is a fixed number of clocks. Slots the instruction does not need become dummy reads. A dummy read re-presents the next address without advancing the pointer, so the same byte is fetched again as the following opcode. A one-byte, two-cycle table-lookup instruction fills four slots: the opcode, two dummies, and a data read at the supplied table address.

An access whose address lies below a configurable boundary goes to the on-chip code store instead of the bus. The address strobe still pulses in that slot, but:

- the read strobe stays inactive;
- the combined port is released;
- the high port shows the contents of a writable port register.

Each slot ends by reporting the captured byte together with a tag that says what kind of read the slot was.

Top module: `pbus_fetch_seq`

## Requirements
- R1: While reset is asserted and before the first slot begins: the address strobe is low, the read strobe (active low) is high, the combined port is released, the high port shows all ones and no byte is reported.
- R2: Each slot lasts 4 clocks. The address strobe is high in exactly the first clock. On an external access the read strobe is low in exactly the last 2 clocks. The two strobes are never active in the same clock.
- R3: On an external access the slot address appears while the address strobe is high, with bits 15:8 on the high port and bits 7:0 on the combined port. The combined port is released while the read strobe is low. The byte on the combined port as the read strobe rises is reported with a one-clock valid pulse in the first clock of the next slot. The reported tag is 0 for opcode, 1 for operand, 2 for dummy and 3 for table data.
- R4: An opcode other than 02h, 74h and 93h (for example E4h) takes one byte and one cycle. It fills an opcode slot at P, then a dummy slot at P+1, and the next opcode is fetched at P+1.
- R5: Opcode 74h takes two bytes and one cycle. It fills an opcode slot at P and an operand slot at P+1, with no dummy slot, and the next opcode is fetched at P+2.
- R6: Opcode 02h takes three bytes and two cycles. It fills an opcode slot, operand slots at P+1 and P+2, and a dummy slot at P+3, and the next opcode is fetched at P+3.
- R7: Opcode 93h takes one byte and two cycles. It fills an opcode slot, two dummy slots at P+1, and a table slot at the table address input, and the next opcode is fetched at P+1.
- R8: An access address below 1000h is internal. The address strobe still pulses, the read strobe stays high for the whole slot, and the combined port stays released. The high port shows the port register. The byte is taken from the internal code data input, for the address on the internal code address output.
- R9: A write on the high-port write inputs loads the port register, which resets to all ones. On an external access the high port still shows the address.
- R10: The pointer-load input is sampled when an instruction starts. If it is high, that opcode is fetched from the pointer input; otherwise the internal pointer is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 16 | Fetch pointer to load at an instruction start |
| pc_load_i | input | 1 | Use pc_i for the next opcode fetch |
| tbl_addr_i | input | 16 | Address for the table data read |
| hiport_wr_i | input | 1 | Write strobe for the high-port register |
| hiport_wdata_i | input | 8 | Data for the high-port register |
| addr_strobe_o | output | 1 | Address latch strobe, active high |
| rd_strobe_n_o | output | 1 | Program read strobe, active low |
| ad_out_o | output | 8 | Low address byte driven on the combined port |
| ad_oe_o | output | 1 | Output enable of the combined port |
| ad_in_i | input | 8 | Data read from the combined port |
| ahi_o | output | 8 | High-address port |
| icode_addr_o | output | 16 | Internal code store address |
| icode_data_i | input | 8 | Internal code store data |
| byte_valid_o | output | 1 | One-clock pulse: a slot's byte was captured |
| byte_o | output | 8 | Captured byte |
| byte_kind_o | output | 2 | Tag of the captured byte (0 opcode, 1 operand, 2 dummy, 3 table) |

## Verification
Two things always share one clock: reporting the byte of the slot that just ended, and launching the next slot's address strobe. After an opcode slot, the new address also depends on the byte captured in that same clock. The bench provokes this with programs whose instruction classes change from slot to slot. It judges each slot's latched address and read-strobe activity against the reported byte and tag, one entry per slot.

A second collision is a high-port register write landing in the first clock of an internal slot. The bench performs that write right after reset, while the first slot is internal. It expects the written value on the high port in that slot, and the address instead when the following slots go external.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [1:0] {
        KIND_OPCODE  = 2'd0,
        KIND_OPERAND = 2'd1,
        KIND_DUMMY   = 2'd2,
        KIND_TABLE   = 2'd3
    } fetch_kind_e;

    // Decoded shape of one instruction.
    typedef struct packed {
        logic [1:0] nbytes;     // 1..3 code bytes
        logic       two_cycle;  // 4 slots instead of 2
        logic       table_rd;   // last slot reads table data
    } op_class_t;

    localparam logic [7:0] OPC_LONG_JUMP = 8'h02;
    localparam logic [7:0] OPC_LOAD_IMM  = 8'h74;
    localparam logic [7:0] OPC_TABLE_RD  = 8'h93;

endpackage

// File: rtl/fseq_op_classifier.sv
module fseq_op_classifier
    import fseq_pkg::*;
(
    input  logic [7:0] opcode_i,
    output op_class_t  class_o
);
    always_comb begin
        class_o = '{nbytes: 2'd1, two_cycle: 1'b0, table_rd: 1'b0};
        case (opcode_i)
            OPC_LONG_JUMP: class_o = '{nbytes: 2'd3, two_cycle: 1'b1, table_rd: 1'b0};
            OPC_LOAD_IMM:  class_o = '{nbytes: 2'd2, two_cycle: 1'b0, table_rd: 1'b0};
            OPC_TABLE_RD:  class_o = '{nbytes: 2'd1, two_cycle: 1'b1, table_rd: 1'b1};
            default:       class_o = '{nbytes: 2'd1, two_cycle: 1'b0, table_rd: 1'b0};
        endcase
    end
endmodule

// File: rtl/fseq_slot_plan.sv
module fseq_slot_plan
    import fseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              new_instr_i,
    input  logic [1:0]        next_slot_i,
    input  op_class_t         class_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_pc_i,
    input  logic [ADDR_W-1:0] tbl_addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output fetch_kind_e       kind_o,
    output logic [ADDR_W-1:0] pc_next_o
);
    logic [ADDR_W-1:0] start_pc;

    assign start_pc = load_i ? load_pc_i : pc_i;

    always_comb begin
        if (new_instr_i) begin
            addr_o    = start_pc;
            kind_o    = KIND_OPCODE;
            pc_next_o = start_pc + 1'b1;
        end else if (class_i.table_rd && next_slot_i == 2'd3) begin
            addr_o    = tbl_addr_i;
            kind_o    = KIND_TABLE;
            pc_next_o = pc_i;
        end else if (next_slot_i < class_i.nbytes) begin
            addr_o    = pc_i;
            kind_o    = KIND_OPERAND;
            pc_next_o = pc_i + 1'b1;
        end else begin
            // Spare slot: show the next address, keep the pointer.
            addr_o    = pc_i;
            kind_o    = KIND_DUMMY;
            pc_next_o = pc_i;
        end
    end
endmodule

// File: rtl/fseq_bus_drive.sv
module fseq_bus_drive #(
    parameter int ADDR_W    = 16,
    parameter int PHASES    = 4,
    parameter int STROBE_PH = 2,
    localparam int PW       = $clog2(PHASES),
    localparam int HI_W     = ADDR_W - 8
) (
    input  logic              active_i,
    input  logic [PW-1:0]     phase_i,
    input  logic              ext_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [HI_W-1:0]   hi_reg_i,
    output logic              ale_o,
    output logic              rd_n_o,
    output logic [7:0]        ad_out_o,
    output logic              ad_oe_o,
    output logic [HI_W-1:0]   ahi_o
);
    localparam logic [PW-1:0] STROBE_FIRST = PW'(PHASES - STROBE_PH);

    logic bus_slot;

    assign bus_slot = active_i && ext_i;
    assign ale_o    = active_i && (phase_i == '0);
    assign rd_n_o   = !(bus_slot && (phase_i >= STROBE_FIRST));
    assign ad_oe_o  = bus_slot && (phase_i < STROBE_FIRST);
    assign ad_out_o = bus_slot ? addr_i[7:0] : 8'h00;
    assign ahi_o    = bus_slot ? addr_i[ADDR_W-1:8] : hi_reg_i;
endmodule

// File: rtl/pbus_fetch_seq.sv
module pbus_fetch_seq
    import fseq_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int unsigned INT_LIMIT = 4096,
    parameter int          PHASES    = 4,
    parameter int          STROBE_PH = 2,
    parameter int unsigned RESET_PC  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              pc_load_i,
    input  logic [ADDR_W-1:0] tbl_addr_i,
    input  logic              hiport_wr_i,
    input  logic [ADDR_W-9:0] hiport_wdata_i,
    output logic              addr_strobe_o,
    output logic              rd_strobe_n_o,
    output logic [7:0]        ad_out_o,
    output logic              ad_oe_o,
    input  logic [7:0]        ad_in_i,
    output logic [ADDR_W-9:0] ahi_o,
    output logic [ADDR_W-1:0] icode_addr_o,
    input  logic [7:0]        icode_data_i,
    output logic              byte_valid_o,
    output logic [7:0]        byte_o,
    output logic [1:0]        byte_kind_o
);
    localparam int              PW          = $clog2(PHASES);
    localparam int              HI_W        = ADDR_W - 8;
    localparam logic [PW-1:0]   LAST_PH     = PW'(PHASES - 1);
    localparam logic [ADDR_W-1:0] INT_LIMIT_A = ADDR_W'(INT_LIMIT);
    localparam logic [ADDR_W-1:0] RESET_PC_A  = ADDR_W'(RESET_PC);

    typedef struct packed {
        logic              active;
        logic [PW-1:0]     phase;
        logic [1:0]        slot;
        op_class_t         cls;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] addr;
        logic              ext;
        fetch_kind_e       kind;
        logic [HI_W-1:0]   hi_reg;
        logic              bvalid;
        logic [7:0]        bdata;
        fetch_kind_e       bkind;
    } seq_state_t;

    typedef struct packed {
        logic              ale;
        logic              rd_n;
        logic [7:0]        ad_out;
        logic              ad_oe;
        logic [HI_W-1:0]   ahi;
    } pins_t;

    seq_state_t state_d, state_q;
    pins_t      pins_d, pins_q;

    // ---- slot boundary decisions ----
    logic              slot_end;
    logic [7:0]        cap_byte;
    op_class_t         byte_cls;
    op_class_t         cur_cls;
    logic [1:0]        last_slot;
    logic              new_instr;
    logic [1:0]        next_slot;
    logic [ADDR_W-1:0] plan_addr;
    fetch_kind_e       plan_kind;
    logic [ADDR_W-1:0] plan_pc;

    assign slot_end  = state_q.active && (state_q.phase == LAST_PH);
    assign cap_byte  = state_q.ext ? ad_in_i : icode_data_i;
    assign cur_cls   = (state_q.slot == 2'd0) ? byte_cls : state_q.cls;
    assign last_slot = cur_cls.two_cycle ? 2'd3 : 2'd1;
    assign new_instr = !state_q.active || (state_q.slot == last_slot);
    assign next_slot = new_instr ? 2'd0 : state_q.slot + 2'd1;

    fseq_op_classifier u_cls (
        .opcode_i (cap_byte),
        .class_o  (byte_cls)
    );

    fseq_slot_plan #(.ADDR_W(ADDR_W)) u_plan (
        .new_instr_i (new_instr),
        .next_slot_i (next_slot),
        .class_i     (cur_cls),
        .pc_i        (state_q.pc),
        .load_i      (pc_load_i),
        .load_pc_i   (pc_i),
        .tbl_addr_i  (tbl_addr_i),
        .addr_o      (plan_addr),
        .kind_o      (plan_kind),
        .pc_next_o   (plan_pc)
    );

    always_comb begin
        state_d        = state_q;
        state_d.bvalid = 1'b0;
        if (hiport_wr_i) begin
            state_d.hi_reg = hiport_wdata_i;
        end
        if (!state_q.active || slot_end) begin
            state_d.active = 1'b1;
            state_d.phase  = '0;
            state_d.slot   = next_slot;
            state_d.cls    = cur_cls;
            state_d.pc     = plan_pc;
            state_d.addr   = plan_addr;
            state_d.kind   = plan_kind;
            state_d.ext    = (plan_addr >= INT_LIMIT_A);
            if (state_q.active) begin
                state_d.bvalid = 1'b1;
                state_d.bdata  = cap_byte;
                state_d.bkind  = state_q.kind;
            end
        end else begin
            state_d.phase = state_q.phase + 1'b1;
        end
    end

    // Pins are derived from the next state so they leave a flop.
    fseq_bus_drive #(
        .ADDR_W    (ADDR_W),
        .PHASES    (PHASES),
        .STROBE_PH (STROBE_PH)
    ) u_drive (
        .active_i (state_d.active),
        .phase_i  (state_d.phase),
        .ext_i    (state_d.ext),
        .addr_i   (state_d.addr),
        .hi_reg_i (state_d.hi_reg),
        .ale_o    (pins_d.ale),
        .rd_n_o   (pins_d.rd_n),
        .ad_out_o (pins_d.ad_out),
        .ad_oe_o  (pins_d.ad_oe),
        .ahi_o    (pins_d.ahi)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.active <= 1'b0;
            state_q.phase  <= '0;
            state_q.slot   <= 2'd0;
            state_q.cls    <= '0;
            state_q.pc     <= RESET_PC_A;
            state_q.addr   <= RESET_PC_A;
            state_q.ext    <= 1'b0;
            state_q.kind   <= KIND_OPCODE;
            state_q.hi_reg <= '1;
            state_q.bvalid <= 1'b0;
            state_q.bdata  <= 8'h00;
            state_q.bkind  <= KIND_OPCODE;
            pins_q.ale     <= 1'b0;
            pins_q.rd_n    <= 1'b1;
            pins_q.ad_out  <= 8'h00;
            pins_q.ad_oe   <= 1'b0;
            pins_q.ahi     <= '1;
        end else begin
            state_q <= state_d;
            pins_q  <= pins_d;
        end
    end

    assign addr_strobe_o = pins_q.ale;
    assign rd_strobe_n_o = pins_q.rd_n;
    assign ad_out_o      = pins_q.ad_out;
    assign ad_oe_o       = pins_q.ad_oe;
    assign ahi_o         = pins_q.ahi;
    assign icode_addr_o  = state_q.addr;
    assign byte_valid_o  = state_q.bvalid;
    assign byte_o        = state_q.bdata;
    assign byte_kind_o   = state_q.bkind;

endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
    parameter int HI_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ale,
    input logic            rd_n,
    input logic            ad_oe,
    input logic            bvalid,
    input logic [HI_W-1:0] ahi,
    input logic [HI_W-1:0] hi_reg
);
    assert_strobes_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale && !rd_n));

    assert_ale_one_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |=> !ale);

    assert_port_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    assert_byte_with_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> ale);

    assert_internal_hiport_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && !ad_oe) |-> (ahi == hi_reg));
endmodule

bind pbus_fetch_seq fseq_checker #(.HI_W(ADDR_W - 8)) u_fseq_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ale    (addr_strobe_o),
    .rd_n   (rd_strobe_n_o),
    .ad_oe  (ad_oe_o),
    .bvalid (byte_valid_o),
    .ahi    (ahi_o),
    .hi_reg (state_q.hi_reg)
);

// File: tb/tb_pbus_fetch_seq.sv
module tb_pbus_fetch_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pc_i = 16'h0;
    logic        pc_load = 1'b0;
    logic [15:0] tbl_addr = 16'h0;
    logic        hi_wr = 1'b0;
    logic [7:0]  hi_data = 8'h0;
    logic        ale, rd_n, ad_oe, bvalid;
    logic [7:0]  ad_out, ad_in, ahi, bdata, icode_data;
    logic [1:0]  bkind;
    logic [15:0] icode_addr;
    logic [15:0] lat = 16'h0;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] ext_mem(logic [15:0] a);
        case (a)
            16'h2018: return 8'hE4;
            16'h2019: return 8'h93;
            16'h201A: return 8'h02;
            16'h201B: return 8'h30;
            16'h201C: return 8'h5C;
            16'h2200: return 8'h93;
            16'h1000: return 8'h74;
            16'h1001: return 8'h11;
            default:  return a[7:0] ^ 8'h3C;
        endcase
    endfunction

    function automatic logic [7:0] int_mem(logic [15:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction

    always @(negedge ale) lat = {ahi, ad_out};
    assign ad_in      = rd_n ? 8'hEE : ext_mem(lat);
    assign icode_data = int_mem(icode_addr);

    pbus_fetch_seq dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .pc_i           (pc_i),
        .pc_load_i      (pc_load),
        .tbl_addr_i     (tbl_addr),
        .hiport_wr_i    (hi_wr),
        .hiport_wdata_i (hi_data),
        .addr_strobe_o  (ale),
        .rd_strobe_n_o  (rd_n),
        .ad_out_o       (ad_out),
        .ad_oe_o        (ad_oe),
        .ad_in_i        (ad_in),
        .ahi_o          (ahi),
        .icode_addr_o   (icode_addr),
        .icode_data_i   (icode_data),
        .byte_valid_o   (bvalid),
        .byte_o         (bdata),
        .byte_kind_o    (bkind)
    );

    // ---- slot monitor ----
    logic        mon_clr = 1'b1;
    int          cyc = 0;
    int          nslot, nbyte, overlap;
    logic [15:0] s_addr  [0:15];
    logic        s_oe    [0:15];
    int          s_psen  [0:15];
    int          s_start [0:15];
    logic [7:0]  b_data  [0:15];
    logic [1:0]  b_kind  [0:15];
    logic [7:0]  p2_exp = 8'hFF;

    always @(negedge clk) begin
        cyc++;
        if (mon_clr) begin
            nslot = 0; nbyte = 0; overlap = 0;
        end else begin
            if (ale && !rd_n) overlap++;
            if (bvalid && nbyte < 16) begin
                b_data[nbyte] = bdata;
                b_kind[nbyte] = bkind;
                nbyte++;
            end
            if (ale && nslot < 16) begin
                s_addr[nslot]  = {ahi, ad_out};
                s_oe[nslot]    = ad_oe;
                s_start[nslot] = cyc;
                s_psen[nslot]  = 0;
                nslot++;
            end else if (!rd_n && nslot > 0 && nslot < 16) begin
                s_psen[nslot-1]++;
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic start_run(logic [15:0] pc, bit hold, bit wr_hi, logic [7:0] hv,
                             logic [15:0] tbl);
        @(posedge clk); #1;
        rst_n = 1'b0; mon_clr = 1'b1; pc_i = pc; pc_load = 1'b1; tbl_addr = tbl;
        hi_wr = 1'b0;
        p2_exp = wr_hi ? hv : 8'hFF;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1; mon_clr = 1'b0; hi_wr = wr_hi; hi_data = hv;
        @(posedge clk); #1;
        hi_wr = 1'b0;
        if (!hold) pc_load = 1'b0;
        for (int g = 0; g < 400 && nslot < 13; g++) @(posedge clk);
        pc_load = 1'b0;
        chk(nslot >= 13, "R2", nslot, 13);
        chk(overlap == 0, "R2", overlap, 0);
    endtask

    task automatic expect_slot(int i, logic [15:0] a, logic [1:0] k, string req);
        bit ext;
        logic [7:0] bexp;
        ext  = (a >= 16'h1000);
        bexp = ext ? ext_mem(a) : int_mem(a);
        if (ext) begin
            chk(s_addr[i] == a, req, s_addr[i], a);
            chk(s_oe[i] == 1'b1, "R3", s_oe[i], 1);
            chk(ext_mem(a) == bexp && s_psen[i] == 2, "R2", s_psen[i], 2);
        end else begin
            chk(s_addr[i][15:8] == p2_exp, "R8", s_addr[i][15:8], p2_exp);
            chk(s_oe[i] == 1'b0, "R8", s_oe[i], 0);
            chk(s_psen[i] == 0, "R8", s_psen[i], 0);
        end
        chk(b_data[i] == bexp, req, b_data[i], bexp);
        chk(b_kind[i] == k, req, b_kind[i], k);
        if (i > 0) chk(s_start[i] - s_start[i-1] == 4, "R2", s_start[i] - s_start[i-1], 4);
    endtask

    // R1: idle pin state under reset, port register write ignored in reset
    task automatic test_reset_state();
        @(posedge clk); #1;
        rst_n = 1'b0; hi_wr = 1'b1; hi_data = 8'h12;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ale == 1'b0, "R1", ale, 0);
        chk(rd_n == 1'b1, "R1", rd_n, 1);
        chk(ad_oe == 1'b0, "R1", ad_oe, 0);
        chk(ahi == 8'hFF, "R1", ahi, 8'hFF);
        chk(bvalid == 1'b0, "R1", bvalid, 0);
        @(posedge clk); #1;
        hi_wr = 1'b0;
    endtask

    // R4, R6, R7 with an internal table read (R8), reset port value (R9)
    task automatic test_mixed_program();
        start_run(16'h2018, 1'b0, 1'b0, 8'h00, 16'h0000);
        expect_slot(0,  16'h2018, 2'd0, "R4");
        expect_slot(1,  16'h2019, 2'd2, "R4");
        expect_slot(2,  16'h2019, 2'd0, "R7");
        expect_slot(3,  16'h201A, 2'd2, "R7");
        expect_slot(4,  16'h201A, 2'd2, "R7");
        expect_slot(5,  16'h0000, 2'd3, "R7");
        expect_slot(6,  16'h201A, 2'd0, "R6");
        expect_slot(7,  16'h201B, 2'd1, "R6");
        expect_slot(8,  16'h201C, 2'd1, "R6");
        expect_slot(9,  16'h201D, 2'd2, "R6");
        expect_slot(10, 16'h201D, 2'd0, "R6");
        expect_slot(11, 16'h201E, 2'd2, "R4");
    endtask

    // R7: table read going to the external bus
    task automatic test_external_table();
        start_run(16'h2200, 1'b0, 1'b0, 8'h00, 16'h3456);
        expect_slot(0, 16'h2200, 2'd0, "R7");
        expect_slot(1, 16'h2201, 2'd2, "R7");
        expect_slot(2, 16'h2201, 2'd2, "R7");
        expect_slot(3, 16'h3456, 2'd3, "R7");
        expect_slot(4, 16'h2201, 2'd0, "R7");
    endtask

    // R8, R9: code running internally shows the written port register
    task automatic test_internal_run();
        start_run(16'h0040, 1'b0, 1'b1, 8'h5A, 16'h0000);
        expect_slot(0, 16'h0040, 2'd0, "R8");
        expect_slot(1, 16'h0041, 2'd2, "R8");
        expect_slot(2, 16'h0041, 2'd0, "R9");
        expect_slot(3, 16'h0042, 2'd2, "R9");
        expect_slot(4, 16'h0042, 2'd0, "R8");
    endtask

    // R5, R8, R9: boundary crossing with a two-byte instruction
    task automatic test_boundary();
        start_run(16'h0FFF, 1'b0, 1'b1, 8'hC3, 16'h0000);
        expect_slot(0, 16'h0FFF, 2'd0, "R8");
        expect_slot(1, 16'h1000, 2'd2, "R9");
        expect_slot(2, 16'h1000, 2'd0, "R5");
        expect_slot(3, 16'h1001, 2'd1, "R5");
        expect_slot(4, 16'h1002, 2'd0, "R5");
        expect_slot(5, 16'h1003, 2'd2, "R5");
    endtask

    // R10: load held high is taken at every instruction start
    task automatic test_load_hold();
        start_run(16'h2100, 1'b1, 1'b0, 8'h00, 16'h0000);
        expect_slot(0, 16'h2100, 2'd0, "R10");
        expect_slot(1, 16'h2101, 2'd2, "R10");
        expect_slot(2, 16'h2100, 2'd0, "R10");
        expect_slot(3, 16'h2101, 2'd2, "R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        test_reset_state();
        test_mixed_program();
        test_external_table();
        test_internal_run();
        test_boundary();
        test_load_hold();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule